// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block turns the address and control lines of a 16-bit processor bus with a 1 MB (20-bit) address space into chip selects for two memory regions. Each region is 16 bits wide and built from two byte-wide chips. The even chip holds the low byte and the odd chip holds the high byte. Program ROM sits at the top of the space, so the reset fetch at FFFF0h lands in it. Data RAM sits at the bottom, so the interrupt vector table can be written. The block is purely combinational.

A 3-to-8 block decoder forms the 8 KB region selects, which are active low. The two memories use two of these slots, and the other six are brought out for expansion. The decoder has three enables, and all three must be asserted: a memory cycle, a strobe present, and, when full decoding is chosen, a window match. The parameter `FULL_DECODE` picks between two modes. In full decoding every address line above the in-chip lines takes part, so each chip answers at exactly one address. In linear decoding only A19 takes part, which leaves shadow copies of each region across half the space. The byte lanes come from A0 and the active-low bus-high-enable, not from the address alone.

Top module: `mem_cs_decoder`

## Requirements
- R1: When `mio` is 0 (an I/O cycle), all four chip selects, all eight `region_sel_n` bits, `mem_rd_n` and `mem_wr_n` are 1.
- R2: Within a selected region, the even chip select is low only when A0 is 0, and the odd chip select is low only when `bhe_n` is 0. When both are 0 (a word access), both chip selects are low together.
- R3: With full decoding, the ROM pair is selected only for FE000h–FFFFFh. This range includes FFFF0h.
- R4: With full decoding, the RAM pair is selected only for 00000h–01FFFh.
- R5: With full decoding, addresses outside those two ranges select no chip. Examples are 02000h, F8000h and 7E000h.
- R6: With linear decoding, RAM is selected whenever A19 is 0 and ROM whenever A19 is 1. A13–A18 have no effect in this mode. For example, 7E000h reaches RAM.
- R7: A ROM chip select is never low while `wr_n` is 0. A RAM chip select can be low during a write.
- R8: When `rd_n` and `wr_n` are both 1, no chip select and no region select is low.
- R9: With full decoding, `region_sel_n[i]` is low when all of the following hold: it is a strobed memory cycle, A18–A15 all equal A19, and i = {A19,A14,A13}. At most one bit of `region_sel_n` is low at any time. With linear decoding, only bit 0 (A19=0) or bit 7 (A19=1) can be low.
- R10: `chip_addr` equals A12–A1. In a memory cycle, `mem_rd_n` follows `rd_n` and `mem_wr_n` follows `wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 20 | Byte address, A19..A0 |
| bhe_n | input | 1 | Bus-high-enable, active low; selects the odd byte lane |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_even_cs_n | output | 1 | ROM low-byte chip select |
| rom_odd_cs_n | output | 1 | ROM high-byte chip select |
| ram_even_cs_n | output | 1 | RAM low-byte chip select |
| ram_odd_cs_n | output | 1 | RAM high-byte chip select |
| mem_rd_n | output | 1 | Memory read enable, active low |
| mem_wr_n | output | 1 | Memory write enable, active low |
| chip_addr | output | 12 | In-chip word address, A12..A1 |
| region_sel_n | output | 8 | Active-low 8 KB block selects from the 3-to-8 decoder |

## Verification
The hardest cases to reach are the aliases. These are an address that full decoding must reject but linear decoding must accept, such as 7E000h, and a slot whose low three bits match but whose window bits do not. The bench instantiates the block twice, once per mode. It drives the same alias addresses into both instances and expects opposite answers. It also steps through the window boundary so that exactly one window bit is wrong.

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder #(
  parameter int ADDR_W      = 20,
  parameter int CHIP_AW     = 12,
  parameter bit FULL_DECODE = 1'b1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               bhe_n,
  input  logic               mio,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic               rom_even_cs_n,
  output logic               rom_odd_cs_n,
  output logic               ram_even_cs_n,
  output logic               ram_odd_cs_n,
  output logic               mem_rd_n,
  output logic               mem_wr_n,
  output logic [CHIP_AW-1:0] chip_addr,
  output logic [7:0]         region_sel_n
);
  localparam int SEL_LO = CHIP_AW + 1;
  localparam int WIN_LO = CHIP_AW + 3;
  localparam int WIN_W  = ADDR_W - 1 - WIN_LO;

  logic       top;
  logic       win_ok;
  logic       g1, g2a_n, g2b_n;
  logic [2:0] sel;
  logic       lane_even, lane_odd;

  assign top = addr[ADDR_W-1];

  generate
    if (FULL_DECODE) begin : g_full
      assign win_ok = (addr[ADDR_W-2:WIN_LO] == {WIN_W{top}});
      assign sel    = {top, addr[SEL_LO+1:SEL_LO]};
    end else begin : g_linear
      assign win_ok = 1'b1;
      assign sel    = {3{top}};
    end
  endgenerate

  assign g1    = mio;
  assign g2a_n = rd_n & wr_n;
  assign g2b_n = ~win_ok;

  for (genvar i = 0; i < 8; i++) begin : g_dec
    assign region_sel_n[i] = ~(g1 & ~g2a_n & ~g2b_n & (sel == 3'(i)));
  end

  assign lane_even = ~addr[0];
  assign lane_odd  = ~bhe_n;

  assign ram_even_cs_n = ~(~region_sel_n[0] & lane_even);
  assign ram_odd_cs_n  = ~(~region_sel_n[0] & lane_odd);
  assign rom_even_cs_n = ~(~region_sel_n[7] & lane_even & wr_n);
  assign rom_odd_cs_n  = ~(~region_sel_n[7] & lane_odd & wr_n);

  assign mem_rd_n  = rd_n | ~mio;
  assign mem_wr_n  = wr_n | ~mio;
  assign chip_addr = addr[CHIP_AW:1];
endmodule

module mem_cs_decoder_chk #(
  parameter int ADDR_W      = 20,
  parameter int CHIP_AW     = 12,
  parameter bit FULL_DECODE = 1'b1
) (
  input logic [ADDR_W-1:0]  addr,
  input logic               bhe_n,
  input logic               mio,
  input logic               rd_n,
  input logic               wr_n,
  input logic               rom_even_cs_n,
  input logic               rom_odd_cs_n,
  input logic               ram_even_cs_n,
  input logic               ram_odd_cs_n,
  input logic               mem_rd_n,
  input logic               mem_wr_n,
  input logic [CHIP_AW-1:0] chip_addr,
  input logic [7:0]         region_sel_n
);
  always_comb begin
    // R1
    io_quiet_chk: assert (mio || (rom_even_cs_n && rom_odd_cs_n && ram_even_cs_n
                          && ram_odd_cs_n && mem_rd_n && mem_wr_n && &region_sel_n));
    // R2
    even_lane_chk: assert ((rom_even_cs_n && ram_even_cs_n) || !addr[0]);
    // R2
    odd_lane_chk: assert ((rom_odd_cs_n && ram_odd_cs_n) || !bhe_n);
    // R7
    rom_no_write_chk: assert (wr_n || (rom_even_cs_n && rom_odd_cs_n));
    // R8
    strobe_needed_chk: assert (!(rd_n && wr_n) || (&region_sel_n && rom_even_cs_n
                               && rom_odd_cs_n && ram_even_cs_n && ram_odd_cs_n));
    // R9
    region_onehot_chk: assert ($onehot0(~region_sel_n));
    // R6
    linear_alias_chk: assert (FULL_DECODE || !mio || rd_n || addr[ADDR_W-1]
                              || addr[0] || !ram_even_cs_n);
    // R10
    chip_addr_chk: assert (chip_addr == addr[CHIP_AW:1]);
  end
endmodule

bind mem_cs_decoder mem_cs_decoder_chk #(
  .ADDR_W(ADDR_W), .CHIP_AW(CHIP_AW), .FULL_DECODE(FULL_DECODE)
) u_chk (
  .addr(addr), .bhe_n(bhe_n), .mio(mio), .rd_n(rd_n), .wr_n(wr_n),
  .rom_even_cs_n(rom_even_cs_n), .rom_odd_cs_n(rom_odd_cs_n),
  .ram_even_cs_n(ram_even_cs_n), .ram_odd_cs_n(ram_odd_cs_n),
  .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .chip_addr(chip_addr),
  .region_sel_n(region_sel_n)
);

// File: tb/mem_cs_decoder_tb.sv
module mem_cs_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr = '0;
  logic        bhe_n = 1'b1;
  logic        mio = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  int          n_chk = 0;
  int          n_fail = 0;

  logic        f_re, f_ro, f_me, f_mo, f_mrd, f_mwr;
  logic [11:0] f_ca;
  logic [7:0]  f_rs;
  logic        l_re, l_ro, l_me, l_mo, l_mrd, l_mwr;
  logic [11:0] l_ca;
  logic [7:0]  l_rs;

  always #10 clk = ~clk;

  mem_cs_decoder #(.FULL_DECODE(1'b1)) u_dut (
    .addr(addr), .bhe_n(bhe_n), .mio(mio), .rd_n(rd_n), .wr_n(wr_n),
    .rom_even_cs_n(f_re), .rom_odd_cs_n(f_ro), .ram_even_cs_n(f_me),
    .ram_odd_cs_n(f_mo), .mem_rd_n(f_mrd), .mem_wr_n(f_mwr),
    .chip_addr(f_ca), .region_sel_n(f_rs));

  mem_cs_decoder #(.FULL_DECODE(1'b0)) u_dut_lin (
    .addr(addr), .bhe_n(bhe_n), .mio(mio), .rd_n(rd_n), .wr_n(wr_n),
    .rom_even_cs_n(l_re), .rom_odd_cs_n(l_ro), .ram_even_cs_n(l_me),
    .ram_odd_cs_n(l_mo), .mem_rd_n(l_mrd), .mem_wr_n(l_mwr),
    .chip_addr(l_ca), .region_sel_n(l_rs));

  task automatic drive(input logic [19:0] a, input logic b, input logic m,
                       input logic r, input logic w);
    @(negedge clk);
    addr = a; bhe_n = b; mio = m; rd_n = r; wr_n = w;
    #5;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cs order: {rom_even, rom_odd, ram_even, ram_odd}
  task automatic t_reset_idle;
    check("R1 idle full cs", {f_re, f_ro, f_me, f_mo}, 4'hF);
    check("R1 idle region", f_rs, 8'hFF);
    check("R1 idle strobes", {f_mrd, f_mwr}, 2'b11);
  endtask

  task automatic t_io_cycle;
    drive(20'h00740, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R1 io full cs", {f_re, f_ro, f_me, f_mo, f_mrd, f_mwr}, 6'h3F);
    check("R1 io region", f_rs, 8'hFF);
    check("R1 io linear cs", {l_re, l_ro, l_me, l_mo, l_mrd}, 5'h1F);
  endtask

  task automatic t_rom_full;
    drive(20'hFFFF0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R3 reset fetch word", {f_re, f_ro, f_me, f_mo}, 4'b0011);
    check("R9 slot7", f_rs, 8'h7F);
    check("R10 read strobe", {f_mrd, f_mwr}, 2'b01);
    drive(20'hFE001, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R2 rom odd byte", {f_re, f_ro, f_me, f_mo}, 4'b1011);
    drive(20'hFC000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R5 below rom", {f_re, f_ro, f_me, f_mo}, 4'hF);
    check("R9 slot6", f_rs, 8'hBF);
  endtask

  task automatic t_ram_full;
    drive(20'h00000, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R4 ram even write", {f_re, f_ro, f_me, f_mo}, 4'b1101);
    check("R10 write strobe", {f_mrd, f_mwr}, 2'b10);
    drive(20'h01FFF, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R2 ram odd top", {f_re, f_ro, f_me, f_mo}, 4'b1110);
    drive(20'h00AAA, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R2 ram word", {f_re, f_ro, f_me, f_mo}, 4'b1100);
    check("R10 chip addr", f_ca, 12'h555);
    check("R9 slot0", f_rs, 8'hFE);
  endtask

  task automatic t_gaps_full;
    drive(20'h02000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R5 02000", {f_re, f_ro, f_me, f_mo}, 4'hF);
    check("R9 slot1", f_rs, 8'hFD);
    drive(20'hF8000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R5 F8000", {f_re, f_ro, f_me, f_mo}, 4'hF);
    check("R9 slot4", f_rs, 8'hEF);
    drive(20'h7E000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R5 7E000 alias", {f_re, f_ro, f_me, f_mo}, 4'hF);
    check("R9 window miss", f_rs, 8'hFF);
    drive(20'h08000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R5 one window bit", {f_me, f_mo}, 2'b11);
  endtask

  task automatic t_linear;
    drive(20'h7E000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R6 7E000 shadow ram", {l_re, l_ro, l_me, l_mo}, 4'b1100);
    check("R9 linear slot0", l_rs, 8'hFE);
    drive(20'h80000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R6 80000 shadow rom", {l_re, l_ro, l_me, l_mo}, 4'b0011);
    check("R9 linear slot7", l_rs, 8'h7F);
    drive(20'h02001, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R2 linear even only", {l_re, l_ro, l_me, l_mo}, 4'hF);
  endtask

  task automatic t_write_rom;
    drive(20'hFFFF0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R7 rom write blocked full", {f_re, f_ro, f_me, f_mo}, 4'hF);
    check("R7 rom write blocked linear", {l_re, l_ro}, 2'b11);
    check("R7 wr enable", f_mwr, 1'b0);
  endtask

  task automatic t_no_strobe;
    drive(20'h00000, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R8 no strobe full", {f_re, f_ro, f_me, f_mo}, 4'hF);
    check("R8 no strobe region", f_rs, 8'hFF);
    check("R8 no strobe linear", {l_me, l_mo}, 2'b11);
    drive(20'h01FFE, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R10 chip addr top", f_ca, 12'hFFF);
  endtask

  initial begin
    #200_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #5;
    t_reset_idle();
    t_io_cycle();
    t_rom_full();
    t_ram_full();
    t_gaps_full();
    t_linear();
    t_write_rom();
    t_no_strobe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule